// File: doc/BRIEF.md
# Balanced-Ternary Triad Arithmetic and Logic Unit

This unit works on 3-trit balanced-ternary words (triads) in which each trit holds -1, 0 or +1. A caller presents the current accumulator triad, a second operand triad, the carry trit, the sign trit and up to three immediate control triads, together with an operation code. One clock edge later the unit returns the new accumulator, the new carry trit and the new sign trit. All three are registered, and a one-cycle valid strobe marks each result.

The unit supports six operations. Two of them are additions with carry: the accumulator plus the second operand, or the accumulator plus an immediate triad. Two are rotates of the accumulator through the carry trit, one in each direction. The last two are programmable tritwise functions. A unary function is defined by one control triad. A binary function over the accumulator and the second operand is defined by a 3×3 table held in nine control trits. Carry and sign are full ternary values, not bits.

Top module: `ternAlu`

## Requirements
- R1: While reset is held and on the first cycle after it, aOut, bcfOut and rsfOut are all-zero (every trit O) and resValid is low.
- R2: Each trit uses a 2-bit code: 00 means O (0), 01 means P (+1), 10 means N (-1). The code 11 on any input is read as O. A triad packs trits with weight 1 in bits [1:0], weight 3 in bits [3:2] and weight 9 in bits [5:4]. No output trit ever carries the code 11.
- R3: opSel 0 (ADD) forms S = A + B + carry in the range -27..+27. The result is written as aOut = S - 27·C, with aOut in -13..+13 and bcfOut = C in {-1, 0, +1}.
- R4: opSel 1 (ADI) does the same as R3, with imm[5:0] taking the place of B.
- R5: After ADD, ADI, OPA or OPB, rsfOut is the sign of the new aOut: N if negative, O if zero, P if positive.
- R6: opSel 2 (RLA) rotates left. The new A has A's middle trit at weight 9, A's low trit at weight 3 and the old carry at weight 1. The new carry is A's weight-9 trit.
- R7: opSel 3 (RRA) rotates right. The new A has the old carry at weight 9, A's weight-9 trit at weight 3 and A's weight-3 trit at weight 1. The new carry is A's weight-1 trit.
- R8: Both rotates pass rsfIn to rsfOut unchanged.
- R9: opSel 4 (OPA) maps each trit of A through imm[5:0]. An input of N selects imm[1:0], O selects imm[3:2] and P selects imm[5:4]. The carry passes through unchanged.
- R10: opSel 5 (OPB) maps each trit pair (a, b) to the trit imm[2k+1:2k] with k = 3·(a+1) + (b+1). The carry passes through unchanged.
- R11: opSel 6 and 7 are reserved. They raise no resValid and leave all outputs holding their previous values. So does any cycle with opValid low.
- R12: A result appears exactly one cycle after opValid is sampled high with a defined opSel, with resValid high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | Operation request |
| opSel | input | 3 | Operation code (0 ADD, 1 ADI, 2 RLA, 3 RRA, 4 OPA, 5 OPB) |
| aIn | input | 6 | Current accumulator triad |
| bIn | input | 6 | Second operand triad |
| bcfIn | input | 2 | Current carry trit |
| rsfIn | input | 2 | Current sign trit |
| imm | input | 18 | Immediate control triads; [5:0] is the first triad |
| resValid | output | 1 | Result strobe |
| aOut | output | 6 | New accumulator triad |
| bcfOut | output | 2 | New carry trit |
| rsfOut | output | 2 | New sign trit |

## Verification
Several properties are checked by assertions on every cycle:
- no output trit is ever coded 11;
- a result follows each accepted operation one cycle later, and idle or reserved cycles keep the outputs stable;
- rotates keep the sign trit, and the tritwise functions keep the carry;
- the sign trit agrees with the sign of the new accumulator.

Only the bench's scenarios can show that the numeric values are right. These include the sum and carry split at the ±13 and ±27 edges, the trit order of the rotates, and the table indexing of the unary and binary functions. The bench compares each result against its own balanced-ternary model over directed and random operations.

// File: rtl/ternAluPkg.sv
package ternAluPkg;

  localparam int TRITS  = 3;
  localparam int TRIADW = 2 * TRITS;
  localparam int IMMW   = 3 * TRIADW;
  localparam int MAXMAG = (3 ** TRITS - 1) / 2;
  localparam int SPAN   = 3 ** TRITS;

  localparam logic [1:0] TRIT_O = 2'b00;
  localparam logic [1:0] TRIT_P = 2'b01;
  localparam logic [1:0] TRIT_N = 2'b10;

  typedef struct packed {
    logic load;
    logic doAdd;
    logic useImm;
    logic rotL;
    logic rotR;
    logic doUna;
    logic doBin;
  } aluStrb_t;

  function automatic logic [1:0] cleanTrit(input logic [1:0] t);
    return (t == 2'b11) ? TRIT_O : t;
  endfunction

  function automatic int tritVal(input logic [1:0] t);
    case (t)
      TRIT_P:  return 1;
      TRIT_N:  return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int triadVal(input logic [TRIADW-1:0] w);
    int s = 0;
    int wt = 1;
    for (int i = 0; i < TRITS; i++) begin
      s = s + wt * tritVal(w[2*i +: 2]);
      wt = wt * 3;
    end
    return s;
  endfunction

  function automatic logic [TRIADW-1:0] triadFromInt(input int v);
    logic [TRIADW-1:0] r;
    int u = v + MAXMAG;
    int d;
    for (int i = 0; i < TRITS; i++) begin
      d = u % 3;
      u = u / 3;
      r[2*i +: 2] = (d == 0) ? TRIT_N : ((d == 1) ? TRIT_O : TRIT_P);
    end
    return r;
  endfunction

  function automatic logic [1:0] signTrit(input logic [TRIADW-1:0] w);
    int v = triadVal(w);
    if (v > 0) return TRIT_P;
    if (v < 0) return TRIT_N;
    return TRIT_O;
  endfunction

endpackage

// File: rtl/ternAluCtrl.sv
module ternAluCtrl
  import ternAluPkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opSel,
  output aluStrb_t   strb
);

  always_comb begin
    strb = '0;
    if (opValid) begin
      case (opSel)
        3'd0: begin strb.load = 1'b1; strb.doAdd = 1'b1; end
        3'd1: begin strb.load = 1'b1; strb.doAdd = 1'b1; strb.useImm = 1'b1; end
        3'd2: begin strb.load = 1'b1; strb.rotL  = 1'b1; end
        3'd3: begin strb.load = 1'b1; strb.rotR  = 1'b1; end
        3'd4: begin strb.load = 1'b1; strb.doUna = 1'b1; end
        3'd5: begin strb.load = 1'b1; strb.doBin = 1'b1; end
        default: strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/ternAluDp.sv
module ternAluDp
  import ternAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  aluStrb_t          strb,
  input  logic [TRIADW-1:0] aIn,
  input  logic [TRIADW-1:0] bIn,
  input  logic [1:0]        bcfIn,
  input  logic [1:0]        rsfIn,
  input  logic [IMMW-1:0]   imm,
  output logic              resValid,
  output logic [TRIADW-1:0] aOut,
  output logic [1:0]        bcfOut,
  output logic [1:0]        rsfOut
);

  logic [TRIADW-1:0] aCln, bCln, addend, sumA, rotLA, rotRA, unaA, binA, nextA;
  logic [1:0]        cCln, sumC, nextC, nextS;
  logic              lastRot;

  always_comb begin
    for (int i = 0; i < TRITS; i++) begin
      aCln[2*i +: 2] = cleanTrit(aIn[2*i +: 2]);
      bCln[2*i +: 2] = cleanTrit(bIn[2*i +: 2]);
    end
    cCln = cleanTrit(bcfIn);
  end

  // Adder: full sum split into in-range triad plus a carry trit of weight SPAN
  always_comb begin
    int full;
    int cv;
    for (int i = 0; i < TRITS; i++)
      addend[2*i +: 2] = strb.useImm ? cleanTrit(imm[2*i +: 2]) : bCln[2*i +: 2];
    full = triadVal(aCln) + triadVal(addend) + tritVal(cCln);
    if (full > MAXMAG)       cv = 1;
    else if (full < -MAXMAG) cv = -1;
    else                     cv = 0;
    sumA = triadFromInt(full - SPAN * cv);
    sumC = (cv > 0) ? TRIT_P : ((cv < 0) ? TRIT_N : TRIT_O);
  end

  // Rotates through carry
  assign rotLA = {aCln[TRIADW-3:0], cCln};
  assign rotRA = {cCln, aCln[TRIADW-1:2]};

  // Per-trit programmable tables
  for (genvar g = 0; g < TRITS; g++) begin : gTrit
    logic [1:0] aT, bT;
    int         idx;
    assign aT = aCln[2*g +: 2];
    assign bT = bCln[2*g +: 2];
    always_comb begin
      case (aT)
        TRIT_N:  unaA[2*g +: 2] = cleanTrit(imm[1:0]);
        TRIT_P:  unaA[2*g +: 2] = cleanTrit(imm[5:4]);
        default: unaA[2*g +: 2] = cleanTrit(imm[3:2]);
      endcase
      idx = 3 * (tritVal(aT) + 1) + (tritVal(bT) + 1);
      binA[2*g +: 2] = cleanTrit(imm[2*idx +: 2]);
    end
  end

  always_comb begin
    nextA = aCln;
    nextC = cCln;
    if (strb.doAdd) begin
      nextA = sumA;
      nextC = sumC;
    end else if (strb.rotL) begin
      nextA = rotLA;
      nextC = aCln[TRIADW-1 -: 2];
    end else if (strb.rotR) begin
      nextA = rotRA;
      nextC = aCln[1:0];
    end else if (strb.doUna) begin
      nextA = unaA;
    end else if (strb.doBin) begin
      nextA = binA;
    end
    nextS = (strb.rotL || strb.rotR) ? cleanTrit(rsfIn) : signTrit(nextA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aOut     <= '0;
      bcfOut   <= TRIT_O;
      rsfOut   <= TRIT_O;
      resValid <= 1'b0;
      lastRot  <= 1'b0;
    end else begin
      resValid <= strb.load;
      if (strb.load) begin
        aOut    <= nextA;
        bcfOut  <= nextC;
        rsfOut  <= nextS;
        lastRot <= strb.rotL || strb.rotR;
      end
    end
  end

  p_codes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (aOut[1:0] != 2'b11) && (aOut[3:2] != 2'b11) && (aOut[5:4] != 2'b11) &&
    (bcfOut != 2'b11) && (rsfOut != 2'b11));

  p_latency_r12: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> resValid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !resValid && $stable(aOut) && $stable(bcfOut) && $stable(rsfOut));

  p_rot_rsf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rotL || strb.rotR) |=> rsfOut == cleanTrit($past(rsfIn)));

  p_fn_carry_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doUna || strb.doBin) |=> bcfOut == cleanTrit($past(bcfIn)));

  p_sign_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !lastRot) |-> rsfOut == signTrit(aOut));

endmodule

// File: rtl/ternAlu.sv
module ternAlu
  import ternAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [TRIADW-1:0] aIn,
  input  logic [TRIADW-1:0] bIn,
  input  logic [1:0]        bcfIn,
  input  logic [1:0]        rsfIn,
  input  logic [IMMW-1:0]   imm,
  output logic              resValid,
  output logic [TRIADW-1:0] aOut,
  output logic [1:0]        bcfOut,
  output logic [1:0]        rsfOut
);

  aluStrb_t strb;

  ternAluCtrl i_ctrl (
    .opValid (opValid),
    .opSel   (opSel),
    .strb    (strb)
  );

  ternAluDp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .aIn      (aIn),
    .bIn      (bIn),
    .bcfIn    (bcfIn),
    .rsfIn    (rsfIn),
    .imm      (imm),
    .resValid (resValid),
    .aOut     (aOut),
    .bcfOut   (bcfOut),
    .rsfOut   (rsfOut)
  );

endmodule

// File: tb/test_ternAlu.sv
module test_ternAlu;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [5:0]  aIn = '0, bIn = '0;
  logic [1:0]  bcfIn = '0, rsfIn = '0;
  logic [17:0] imm = '0;
  logic        resValid;
  logic [5:0]  aOut;
  logic [1:0]  bcfOut, rsfOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [5:0] a;
    logic [1:0] c;
    logic [1:0] s;
    string      tag;
  } exp_t;
  exp_t sb[$];
  logic [5:0] lastA = '0;
  logic [1:0] lastC = '0, lastS = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ternAlu i_ternAlu (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .aIn(aIn), .bIn(bIn), .bcfIn(bcfIn), .rsfIn(rsfIn), .imm(imm),
    .resValid(resValid), .aOut(aOut), .bcfOut(bcfOut), .rsfOut(rsfOut)
  );

  // ---- independent balanced-ternary model ----
  function automatic int mTrit(input logic [1:0] t);
    if (t == 2'b01) return 1;
    if (t == 2'b10) return -1;
    return 0;
  endfunction

  function automatic logic [1:0] mCode(input int v);
    if (v > 0) return 2'b01;
    if (v < 0) return 2'b10;
    return 2'b00;
  endfunction

  function automatic int mVal(input logic [5:0] w);
    return 9 * mTrit(w[5:4]) + 3 * mTrit(w[3:2]) + mTrit(w[1:0]);
  endfunction

  function automatic logic [5:0] mTriad(input int v);
    logic [5:0] r;
    int m;
    for (int i = 0; i < 3; i++) begin
      m = v % 3;
      if (m == 2 || m == -1)      begin r[2*i +: 2] = 2'b10; v = (v + 1) / 3; end
      else if (m == 1 || m == -2) begin r[2*i +: 2] = 2'b01; v = (v - 1) / 3; end
      else                        begin r[2*i +: 2] = 2'b00; v = v / 3; end
    end
    return r;
  endfunction

  function automatic logic [5:0] mClean(input logic [5:0] w);
    return mTriad(mVal(w));
  endfunction

  function automatic exp_t model(input int op, input logic [5:0] a, input logic [5:0] b,
                                 input logic [1:0] c, input logic [1:0] s,
                                 input logic [17:0] im, input string tag);
    exp_t e;
    int full, cy;
    logic [5:0] ac;
    ac = mClean(a);
    e.tag = tag;
    e.c = mCode(mTrit(c));
    e.s = mCode(mTrit(s));
    case (op)
      0, 1: begin
        full = mVal(ac) + ((op == 0) ? mVal(b) : mVal(im[5:0])) + mTrit(c);
        cy = (full > 13) ? 1 : ((full < -13) ? -1 : 0);
        e.a = mTriad(full - 27 * cy);
        e.c = mCode(cy);
      end
      2: begin e.a = {ac[3:0], mCode(mTrit(c))}; e.c = ac[5:4]; end
      3: begin e.a = {mCode(mTrit(c)), ac[5:2]}; e.c = ac[1:0]; end
      4: for (int i = 0; i < 3; i++)
           e.a[2*i +: 2] = mCode(mTrit(im[2*(mTrit(ac[2*i +: 2]) + 1) +: 2]));
      default:
         for (int i = 0; i < 3; i++)
           e.a[2*i +: 2] = mCode(mTrit(im[2*(3*(mTrit(ac[2*i +: 2]) + 1) +
                                   mTrit(b[2*i +: 2]) + 1) +: 2]));
    endcase
    if (op != 2 && op != 3) e.s = mCode(mVal(e.a));
    return e;
  endfunction

  function automatic logic [5:0] tr(input int v);
    return mTriad(v);
  endfunction

  // ---- driver ----
  task automatic drive(input int op, input logic [5:0] a, input logic [5:0] b,
                       input logic [1:0] c, input logic [1:0] s,
                       input logic [17:0] im, input string tag);
    exp_t e;
    @(negedge clk);
    opValid = 1'b1; opSel = op[2:0];
    aIn = a; bIn = b; bcfIn = c; rsfIn = s; imm = im;
    if (op < 6) begin
      e = model(op, a, b, c, s, im, tag);
      sb.push_back(e);
      lastA = e.a; lastC = e.c; lastS = e.s;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // ---- monitor ----
  always @(negedge clk) begin
    exp_t e;
    if (rstN && resValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11", $sformatf("unexpected result a=%b expected no result", aOut));
      end else begin
        e = sb.pop_front();
        check(aOut == e.a && bcfOut == e.c && rsfOut == e.s, e.tag,
              $sformatf("a/c/s actual %b/%b/%b expected %b/%b/%b",
                        aOut, bcfOut, rsfOut, e.a, e.c, e.s));
      end
    end
  end

  // ---- watchdog ----
  initial begin
    int n = 0;
    while (!done && n < WATCHDOG) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---- scenarios ----
  initial begin
    repeat (3) @(negedge clk);
    check(aOut == 6'b0 && bcfOut == 2'b0 && rsfOut == 2'b0 && !resValid, "R1",
          $sformatf("reset outputs %b/%b/%b/%b expected 000000/00/00/0",
                    aOut, bcfOut, rsfOut, resValid));
    rstN = 1'b1;
    @(negedge clk);
    check(aOut == 6'b0 && !resValid, "R1",
          $sformatf("after reset a=%b v=%b expected 000000/0", aOut, resValid));

    // R3 ADD
    drive(0, tr(5),   tr(4),   2'b00, 2'b00, '0, "R3 add 5+4");
    drive(0, tr(13),  tr(13),  2'b01, 2'b00, '0, "R3 add 13+13+1");
    drive(0, tr(-13), tr(-13), 2'b10, 2'b00, '0, "R3 add -13-13-1");
    drive(0, tr(7),   tr(-7),  2'b00, 2'b01, '0, "R3 add to zero");
    drive(0, tr(10),  tr(4),   2'b00, 2'b00, '0, "R3 add 14 wraps");
    // R4 ADI
    drive(1, tr(-5),  tr(13),  2'b01, 2'b00, {12'b0, tr(-3)}, "R4 adi -5-3+1");
    drive(1, tr(12),  tr(0),   2'b00, 2'b00, {12'b0, tr(2)},  "R4 adi 12+2");
    // R6/R7/R8 rotates
    drive(2, 6'b10_01_00, '0, 2'b01, 2'b10, '0, "R6 rla");
    drive(3, 6'b10_01_00, '0, 2'b01, 2'b01, '0, "R7 rra");
    drive(3, 6'b01_00_10, '0, 2'b00, 2'b10, '0, "R8 rra keeps rsf");
    // R9 OPA negate and constant-P tables, carry held
    drive(4, tr(7),  '0, 2'b10, 2'b00, {12'b0, 6'b10_00_01}, "R9 opa negate");
    drive(4, tr(-4), '0, 2'b01, 2'b00, {12'b0, 6'b01_01_01}, "R9 opa const P");
    // R10 OPB min table: k index (a+1)*3+(b+1)
    begin
      logic [17:0] minT;
      for (int ka = -1; ka <= 1; ka++)
        for (int kb = -1; kb <= 1; kb++)
          minT[2*(3*(ka+1)+(kb+1)) +: 2] = mCode((ka < kb) ? ka : kb);
      drive(5, 6'b01_00_10, 6'b00_01_01, 2'b01, 2'b00, minT, "R10 opb min");
      drive(5, 6'b01_01_00, 6'b10_01_01, 2'b00, 2'b00, minT, "R10 opb min 2");
    end
    // R2 code 11 read as O
    drive(0, 6'b11_01_11, 6'b00_00_01, 2'b11, 2'b00, '0, "R2 code 11 input");
    idle();
    idle();
    // R11 reserved ops hold
    drive(6, tr(9), tr(9), 2'b01, 2'b01, '1, "R11");
    drive(7, tr(-9), tr(3), 2'b10, 2'b10, '1, "R11");
    idle();
    check(!resValid && aOut == lastA && bcfOut == lastC && rsfOut == lastS, "R11",
          $sformatf("after reserved a/c/s/v %b/%b/%b/%b expected %b/%b/%b/0",
                    aOut, bcfOut, rsfOut, resValid, lastA, lastC, lastS));
    idle();
    // R12 back-to-back random ops
    for (int n = 0; n < 300; n++) begin
      int op;
      logic [17:0] im;
      op = $urandom_range(0, 7);
      for (int i = 0; i < 9; i++) im[2*i +: 2] = mCode($urandom_range(0, 2) - 1);
      drive(op, tr($urandom_range(0, 26) - 13), tr($urandom_range(0, 26) - 13),
            mCode($urandom_range(0, 2) - 1), mCode($urandom_range(0, 2) - 1), im,
            "R12 random");
    end
    idle();
    idle();
    idle();
    check(sb.size() == 0, "R12", $sformatf("pending %0d expected 0", sb.size()));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule